// File: doc/BRIEF.md
# Prescaled Interval Timer Pair

Two independent 8-bit interval timers are fed from one shared stream of elapsed-clock counts. On every cycle the `tick_i` input gives the number of input clocks that have passed since the last cycle (0 to 255). Each timer feeds these counts into its own prescaler. The prescaler divides by a period chosen from a fixed, non-linear set of powers of two. Every completed period advances the timer's visible count by one. When the count reaches the programmed limit it returns to zero and an interrupt event occurs.

Software programs each timer through a control byte and a data byte on a small byte-wide register bus. The data byte has two roles. A write sets the compare limit, and a read returns the live count. Each timer has a sticky interrupt flag. The flag is set only when the timer's interrupt-enable input and the global enable are both high. Timer 1 has one more condition: the 3-bit priority level input must be below 4. The flag stays set until an acknowledge pulse clears it.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset, both control bytes, both counts and both limits are 0, and both interrupt flags are low.
- R2: While control bit 7 (enable) of a timer is 0, ticks do not change its count.
- R3: With select (control bits 2:0) equal to 0, the prescale period is one input clock. A `tick_i` value of n advances the count by n in a single cycle.
- R4: With select s from 1 to 7, the prescale period is 2^(8+s) input clocks. The accumulator keeps the remainder after each completed period, so no clocks are lost across cycles.
- R5: When an increment makes the count reach or exceed the limit, the count restarts at 0 and a wrap event occurs. Several wraps in one cycle leave the count at (count + increments) mod limit.
- R6: A control write stores the whole byte and clears both the count and the prescale accumulator.
- R7: A data write stores the limit and clears the count. The prescale accumulator keeps its value.
- R8: A timer 0 wrap sets its flag only when `irq_en_i[0]` and `glb_en_i` are both 1.
- R9: A timer 1 wrap sets its flag only when `irq_en_i[1]` and `glb_en_i` are both 1 and `prio_i` is below 4.
- R10: An interrupt flag stays set until `ack_i` is high for that timer. If a new qualified wrap and an acknowledge happen in the same cycle, the flag stays set.
- R11: Register addresses are as follows. Address bit 1 selects the timer, and address bit 0 selects data (1) or control (0). A data read returns the live count, and a control read returns the stored byte. The two timers count independently.
- R12: A limit of 0 behaves like a limit of 1: every increment wraps and the count stays at 0.
- R13: A register write in the same cycle as ticks takes priority: that timer ignores the ticks of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: bit 1 selects the timer, bit 0 selects data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| tick_i | input | 8 | Input clocks elapsed this cycle |
| irq_en_i | input | 2 | Per-timer interrupt enables |
| glb_en_i | input | 1 | Global interrupt enable |
| prio_i | input | 3 | Current priority level; gates timer 1 |
| ack_i | input | 2 | Per-timer interrupt acknowledge |
| irq_o | output | 2 | Sticky interrupt flags |

## Verification
The bench feeds bursts of ticks that exceed the limit several times over in one cycle. A design that wraps only once per cycle, or that resets to zero instead of keeping the remainder, leaves the count at the wrong value. The coarse selects are tested with tick sums that straddle a period boundary. A prescaler that drops its remainder, or that is cleared by a data write, comes out one count short. The tests also cover a limit of 0, a write that collides with ticks, and an acknowledge that collides with a new wrap. A design that mishandles these shows a count that is not zero, a count that moved, or a lost flag. Each gating input, and the priority boundary at 3 versus 4, is toggled on its own so that a missing condition shows up as a spurious flag.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int NUM_TMR = 2;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic       en;
    logic [3:0] spare;
    logic [2:0] sel;
  } ctrl_t;

  // log2 of prescale period: select 0 is a single clock, others 2^(base+sel)
  function automatic logic [4:0] pre_shift(input logic [2:0] sel, input int base);
    if (sel == 3'd0) return 5'd0;
    return 5'(base + int'(sel));
  endfunction
endpackage

// File: rtl/itp_prescale.sv
module itp_prescale #(
  parameter int TICK_W   = 8,
  parameter int PRE_BASE = 8,
  parameter int ACC_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic [2:0]        sel_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [ACC_W:0]    inc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] mask;
  logic [4:0]       shamt;

  assign shamt = itp_pkg::pre_shift(sel_i, PRE_BASE);
  assign sum   = {1'b0, acc_q} + (ACC_W+1)'(tick_i);
  assign mask  = ~({ACC_W{1'b1}} << shamt);
  assign inc_o = run_i ? (sum >> shamt) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (run_i) acc_q <= sum[ACC_W-1:0] & mask;
  end
endmodule

// File: rtl/itp_wrap.sv
module itp_wrap #(
  parameter int CNT_W = 8,
  parameter int IN_W  = 17
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [IN_W-1:0]  inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] next_o,
  output logic             wrap_o
);
  localparam int S_W = IN_W + 1;

  logic [CNT_W-1:0] modulus;
  logic [S_W-1:0]   total;

  assign modulus = (limit_i == '0) ? CNT_W'(1) : limit_i;
  assign total   = S_W'(count_i) + S_W'(inc_i);
  assign wrap_o  = total >= S_W'(modulus);

  // restoring remainder, one bit per stage
  always_comb begin
    logic [CNT_W-1:0] rem;
    logic [CNT_W:0]   t;
    rem = '0;
    for (int i = S_W-1; i >= 0; i--) begin
      t = {rem, total[i]};
      if (t >= {1'b0, modulus}) t = t - {1'b0, modulus};
      rem = t[CNT_W-1:0];
    end
    next_o = rem;
  end
endmodule

// File: rtl/itp_channel.sv
module itp_channel #(
  parameter int TICK_W   = 8,
  parameter int PRE_BASE = 8,
  parameter int CNT_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_ctrl_i,
  input  logic              we_data_i,
  input  logic [7:0]        wdata_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [7:0]        ctrl_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              wrap_o
);
  localparam int ACC_W = PRE_BASE + 8;

  itp_pkg::ctrl_t   ctrl_q;
  logic [CNT_W-1:0] cnt_q, limit_q, cnt_nx;
  logic [ACC_W:0]   inc;
  logic             run, wrap;

  assign run = ctrl_q.en && !we_ctrl_i && !we_data_i;

  itp_prescale #(.TICK_W(TICK_W), .PRE_BASE(PRE_BASE), .ACC_W(ACC_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (we_ctrl_i),
    .run_i (run),
    .sel_i (ctrl_q.sel),
    .tick_i(tick_i),
    .inc_o (inc)
  );

  itp_wrap #(.CNT_W(CNT_W), .IN_W(ACC_W+1)) u_wrap (
    .count_i(cnt_q),
    .inc_i  (inc),
    .limit_i(limit_q),
    .next_o (cnt_nx),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      limit_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (we_ctrl_i) ctrl_q <= itp_pkg::ctrl_t'(wdata_i);
      if (we_data_i) limit_q <= CNT_W'(wdata_i);
      if (we_ctrl_i || we_data_i) cnt_q <= '0;
      else if (run)               cnt_q <= cnt_nx;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign cnt_o   = cnt_q;
  assign limit_o = limit_q;
  assign wrap_o  = run && wrap;
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair #(
  parameter int TICK_W   = 8,
  parameter int PRE_BASE = 8,
  parameter int PRIO_W   = 3,
  parameter int PRIO_LIM = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [1:0]        irq_en_i,
  input  logic              glb_en_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [1:0]        ack_i,
  output logic [1:0]        irq_o
);
  localparam int NT    = itp_pkg::NUM_TMR;
  localparam int CNT_W = itp_pkg::REG_W;

  logic [NT-1:0][7:0]       ctrl_all;
  logic [NT-1:0][CNT_W-1:0] cnt_all;
  logic [NT-1:0][CNT_W-1:0] lim_all;
  logic [NT-1:0]            wrap_all;
  logic [NT-1:0]            gate;
  logic [NT-1:0]            irq_q;

  for (genvar ch = 0; ch < NT; ch++) begin : g_ch
    logic hit;
    assign hit = we_i && (addr_i[1] == 1'(ch));

    itp_channel #(.TICK_W(TICK_W), .PRE_BASE(PRE_BASE), .CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_ctrl_i(hit && !addr_i[0]),
      .we_data_i(hit && addr_i[0]),
      .wdata_i  (wdata_i),
      .tick_i   (tick_i),
      .ctrl_o   (ctrl_all[ch]),
      .cnt_o    (cnt_all[ch]),
      .limit_o  (lim_all[ch]),
      .wrap_o   (wrap_all[ch])
    );

    if (ch == 0) begin : g_plain
      assign gate[ch] = irq_en_i[ch] && glb_en_i;
    end else begin : g_prio
      assign gate[ch] = irq_en_i[ch] && glb_en_i && (prio_i < PRIO_W'(PRIO_LIM));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        irq_q[ch] <= 1'b0;
      else if (wrap_all[ch] && gate[ch])  irq_q[ch] <= 1'b1;
      else if (ack_i[ch])                 irq_q[ch] <= 1'b0;
    end
  end

  assign irq_o   = irq_q;
  assign rdata_o = addr_i[0] ? cnt_all[addr_i[1]] : ctrl_all[addr_i[1]];
endmodule

// File: rtl/itp_checker.sv
module itp_checker (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       irq_o,
  input logic [1:0]       ack_i,
  input logic [1:0]       irq_en_i,
  input logic             glb_en_i,
  input logic [2:0]       prio_i,
  input logic [1:0][7:0]  ctrl_all,
  input logic [1:0][7:0]  cnt_all,
  input logic [1:0][7:0]  lim_all,
  input logic [1:0]       wrap_all
);
  AST_IRQ0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && !ack_i[0]) |=> irq_o[0]); // R10
  AST_IRQ1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[1] && !ack_i[1]) |=> irq_o[1]); // R10
  AST_ACK0_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !wrap_all[0]) |=> !irq_o[0]); // R10
  AST_T0_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> $past(irq_en_i[0] && glb_en_i)); // R8
  AST_T1_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[1]) |-> $past(irq_en_i[1] && glb_en_i && (prio_i < 3'd4))); // R9
  AST_CNT0_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_all[0] == 8'd0) || (cnt_all[0] < lim_all[0])); // R5
  AST_CNT1_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_all[1] == 8'd0) || (cnt_all[1] < lim_all[1])); // R5
  AST_OFF0_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_all[0][7] && !we_i) |=> $stable(cnt_all[0])); // R2
  AST_OFF1_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_all[1][7] && !we_i) |=> $stable(cnt_all[1])); // R2
endmodule

bind interval_timer_pair itp_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .irq_o   (irq_o),
  .ack_i   (ack_i),
  .irq_en_i(irq_en_i),
  .glb_en_i(glb_en_i),
  .prio_i  (prio_i),
  .ctrl_all(ctrl_all),
  .cnt_all (cnt_all),
  .lim_all (lim_all),
  .wrap_all(wrap_all)
);

// File: tb/sim_interval_timer_pair.sv
module sim_interval_timer_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] tick = 8'd0;
  logic [1:0] irq_en = 2'b11;
  logic       glb_en = 1'b1;
  logic [2:0] prio = 3'd0;
  logic [1:0] ack = 2'b00;
  logic [1:0] irq;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  interval_timer_pair u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_en_i(irq_en), .glb_en_i(glb_en),
    .prio_i(prio), .ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic tk(input logic [7:0] n);
    tick = n;
    @(posedge clk); #1;
    tick = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic do_ack(input logic [1:0] m);
    ack = m;
    @(posedge clk); #1;
    ack = 2'b00;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg after reset", v, 8'h00);
    end
    chk("R1 irq after reset", {6'd0, irq}, 8'h00);
  endtask

  task automatic t_disabled;
    wr(2'd0, 8'h00); wr(2'd1, 8'd10);
    tk(8'd5); tk(8'd200);
    rd(2'd1, v); chk("R2 disabled count", v, 8'd0);
  endtask

  task automatic t_fine;
    wr(2'd0, 8'h80); wr(2'd1, 8'd200);
    tk(8'd1); rd(2'd1, v); chk("R3 single tick", v, 8'd1);
    tk(8'd5); rd(2'd1, v); chk("R3 burst of five", v, 8'd6);
  endtask

  task automatic t_wrap;
    do_ack(2'b11);
    tk(8'd255); rd(2'd1, v); chk("R5 wrap remainder", v, 8'd61);
    chk("R5 wrap irq", {7'd0, irq[0]}, 8'd1);
    do_ack(2'b01);
    wr(2'd1, 8'd3);
    tk(8'd10); rd(2'd1, v); chk("R5 multi wrap mod", v, 8'd1);
    do_ack(2'b01);
  endtask

  task automatic t_coarse;
    wr(2'd0, 8'h81); wr(2'd1, 8'd100);
    tk(8'd200); tk(8'd200); rd(2'd1, v); chk("R4 below period", v, 8'd0);
    tk(8'd200); rd(2'd1, v); chk("R4 first period", v, 8'd1);
    tk(8'd255); rd(2'd1, v); chk("R4 remainder kept", v, 8'd1);
    tk(8'd169); rd(2'd1, v); chk("R4 second period", v, 8'd2);
    tk(8'd255); tk(8'd255); rd(2'd1, v); chk("R4 510 clocks", v, 8'd2);
    tk(8'd2); rd(2'd1, v); chk("R4 exact 512", v, 8'd3);
    wr(2'd0, 8'h87);
    for (int i = 0; i < 128; i++) tk(8'd255);
    rd(2'd1, v); chk("R4 sel7 below", v, 8'd0);
    tk(8'd128); rd(2'd1, v); chk("R4 sel7 32768", v, 8'd1);
  endtask

  task automatic t_ctrl_clear;
    wr(2'd0, 8'h81); wr(2'd1, 8'd100);
    tk(8'd255); tk(8'd255); tk(8'd2);
    tk(8'd255); tk(8'd255);
    rd(2'd1, v); chk("R6 before ctrl write", v, 8'd1);
    wr(2'd0, 8'h81);
    rd(2'd1, v); chk("R6 count cleared", v, 8'd0);
    rd(2'd0, v); chk("R6 ctrl stored", v, 8'h81);
    tk(8'd2); rd(2'd1, v); chk("R6 accumulator cleared", v, 8'd0);
    tk(8'd255); tk(8'd255); rd(2'd1, v); chk("R6 fresh period", v, 8'd1);
  endtask

  task automatic t_data_write;
    wr(2'd0, 8'h81); wr(2'd1, 8'd100);
    tk(8'd255); tk(8'd255);
    wr(2'd1, 8'd50);
    rd(2'd1, v); chk("R7 count cleared", v, 8'd0);
    tk(8'd2); rd(2'd1, v); chk("R7 accumulator kept", v, 8'd1);
  endtask

  task automatic t_limit_zero;
    do_ack(2'b11);
    wr(2'd0, 8'h80); wr(2'd1, 8'd0);
    tk(8'd7); rd(2'd1, v); chk("R12 limit zero count", v, 8'd0);
    chk("R12 limit zero irq", {7'd0, irq[0]}, 8'd1);
    do_ack(2'b01);
  endtask

  task automatic t_gate0;
    wr(2'd0, 8'h80); wr(2'd1, 8'd2);
    irq_en = 2'b10; tk(8'd2);
    chk("R8 no irq without enable", {7'd0, irq[0]}, 8'd0);
    irq_en = 2'b11; glb_en = 1'b0; tk(8'd2);
    chk("R8 no irq without global", {7'd0, irq[0]}, 8'd0);
    glb_en = 1'b1; tk(8'd2);
    chk("R8 irq when qualified", {7'd0, irq[0]}, 8'd1);
    do_ack(2'b01);
    chk("R10 ack clears", {7'd0, irq[0]}, 8'd0);
  endtask

  task automatic t_gate1;
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h80); wr(2'd3, 8'd2);
    prio = 3'd4; tk(8'd2);
    chk("R9 prio 4 blocks", {7'd0, irq[1]}, 8'd0);
    prio = 3'd7; tk(8'd2);
    chk("R9 prio 7 blocks", {7'd0, irq[1]}, 8'd0);
    prio = 3'd3; irq_en = 2'b01; tk(8'd2);
    chk("R9 enable blocks", {7'd0, irq[1]}, 8'd0);
    irq_en = 2'b11; tk(8'd2);
    chk("R9 prio 3 passes", {7'd0, irq[1]}, 8'd1);
    chk("R9 timer0 quiet", {7'd0, irq[0]}, 8'd0);
    prio = 3'd0;
  endtask

  task automatic t_sticky;
    tk(8'd0); tk(8'd0);
    chk("R10 flag sticky", {7'd0, irq[1]}, 8'd1);
    do_ack(2'b10);
    chk("R10 ack clears t1", {7'd0, irq[1]}, 8'd0);
    tick = 8'd2; ack = 2'b10;
    @(posedge clk); #1;
    tick = 8'd0; ack = 2'b00;
    chk("R10 set beats ack", {7'd0, irq[1]}, 8'd1);
    do_ack(2'b10);
  endtask

  task automatic t_collide;
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h80); wr(2'd1, 8'd100);
    tk(8'd3); rd(2'd1, v); chk("R13 setup", v, 8'd3);
    tick = 8'd5; wr(2'd1, 8'd100); tick = 8'd0;
    rd(2'd1, v); chk("R13 data write wins", v, 8'd0);
    tick = 8'd9; wr(2'd0, 8'h80); tick = 8'd0;
    rd(2'd1, v); chk("R13 ctrl write wins", v, 8'd0);
  endtask

  task automatic t_independent;
    wr(2'd0, 8'h80); wr(2'd1, 8'd100);
    wr(2'd2, 8'h81); wr(2'd3, 8'd100);
    tk(8'd10);
    rd(2'd1, v); chk("R11 timer0 count", v, 8'd10);
    rd(2'd3, v); chk("R11 timer1 count", v, 8'd0);
    rd(2'd2, v); chk("R11 timer1 ctrl", v, 8'h81);
    rd(2'd0, v); chk("R11 timer0 ctrl", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_disabled;
    t_fine;
    t_wrap;
    t_coarse;
    t_ctrl_clear;
    t_data_write;
    t_limit_zero;
    t_gate0;
    t_gate1;
    t_sticky;
    t_collide;
    t_independent;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule